// File: doc/BRIEF.md
# Input capture channel with post-capture blanking window

This block is one capture channel that sits next to a free-running 16-bit counter. When the selected edge (rising or falling, picked by one select bit) appears on an already synchronized input, the channel stores the counter value in its capture register and raises a sticky flag. Software clears the flag by writing zero to it.

An optional blanking window can follow each capture. While blanking is enabled and the 8-bit blanking length is nonzero, a capture sets an end point. The end point is the captured count plus twice the blanking length, taken modulo 2^16. Edges are discarded until the counter reaches that end point on a tick cycle. This suppresses bounce or ringing that follows a real event. The blanking length lives in a 16-bit register whose upper byte always reads as zero.

Top module: `icm_capture_mask`

## Requirements
- R1: After reset the capture register reads 16'h0000, the capture flag reads 0 and the blanking-length register reads 16'h0000.
- R2: A 16-bit write to the blanking-length register stores bits 7:0. Bits 15:8 of the write data are ignored, so the register always reads {8'h00, stored byte}.
- R3: With edge_sel = 0 a 0-to-1 change of cap_in is a capture edge, and with edge_sel = 1 a 1-to-0 change is. An accepted edge loads cnt_val into cap_value, which shows the new value in the cycle after the edge cycle. The opposite edge captures nothing.
- R4: An accepted capture opens a blanking window when mask_en = 1 and the blanking length is nonzero at that moment. Every edge inside the window is discarded and leaves cap_value and cap_flag unchanged.
- R5: The window closes on the cycle where cnt_tick = 1 and cnt_val equals (captured value + 2 × blanking length) mod 2^16. An edge on that closing cycle is still discarded. An edge one cycle later is accepted.
- R6: With mask_en = 0, or with a blanking length of zero, no window opens, and back-to-back edges are each captured.
- R7: The end point is fixed at capture time. Writing the blanking-length register while a window is open does not move the end of that window.
- R8: Each accepted capture sets cap_flag, which stays set. A write with flag_wd = 0 clears it and a write with flag_wd = 1 leaves it unchanged. If a capture and a clearing write fall in the same cycle, the flag ends up set.
- R9: A cycle with cnt_tick = 0 never closes a window, even when cnt_val equals the end point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 16 | Current free-running counter value |
| cnt_tick | input | 1 | High on cycles where cnt_val is a freshly advanced count |
| cap_in | input | 1 | Synchronized capture input level |
| edge_sel | input | 1 | 0: rising edge captures, 1: falling edge captures |
| mask_en | input | 1 | Enables the blanking window after a capture |
| mlen_we | input | 1 | Write strobe for the blanking-length register |
| mlen_wd | input | 16 | Write data for the blanking-length register |
| mlen_rd | output | 16 | Blanking-length register read value, upper byte zero |
| flag_we | input | 1 | Write strobe for the capture flag |
| flag_wd | input | 1 | Capture flag write data; 0 clears |
| cap_value | output | 16 | Capture register read value |
| cap_flag | output | 1 | Sticky capture flag |

## Verification
Every result comes from a single register stage. A capture, a flag update or a register write presented while the clock is low shows at the ports one rising edge later. The bench drives its inputs on the falling edge and reads outputs on the next falling edge, one clock after the stimulus. Windows are checked indirectly: the bench presents edges on chosen counter values, then reads whether cap_value moved in the following cycle. This covers the closing cycle itself, the cycle after it, a tick-less cycle at the end point, and an end point that wraps past 16'hFFFF.

// File: rtl/icm_pkg.sv
package icm_pkg;
  localparam int CNT_W  = 16;
  localparam int MLEN_W = 8;

  typedef enum logic [0:0] {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } edge_sel_e;
endpackage

// File: rtl/icm_edge_det.sv
module icm_edge_det
  import icm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      level_i,
  input  edge_sel_e sel_i,
  output logic      pulse_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = level_i;
    unique case (sel_i)
      EDGE_RISE: pulse_o = level_i & ~prev_q;
      EDGE_FALL: pulse_o = ~level_i & prev_q;
      default:   pulse_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/icm_mask_win.sv
module icm_mask_win #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] span_i,
  input  logic [CNT_W-1:0] cnt_val_i,
  input  logic             cnt_tick_i,
  output logic             active_o
);
  logic             active_q, active_d;
  logic [CNT_W-1:0] end_q, end_d;
  logic             hit;
  logic             end_en;

  assign hit    = active_q & cnt_tick_i & (cnt_val_i == end_q);
  assign end_en = accept_i;

  always_comb begin
    active_d = active_q;
    end_d    = end_q;
    if (hit)      active_d = 1'b0;
    if (accept_i) begin
      active_d = arm_i;
      end_d    = base_i + span_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      end_q <= '0;
    else if (end_en) end_q <= end_d;
  end

  assign active_o = active_q;
endmodule

// File: rtl/icm_cap_regs.sv
module icm_cap_regs #(
  parameter int CNT_W  = 16,
  parameter int MLEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [CNT_W-1:0]  cnt_val_i,
  input  logic              flag_we_i,
  input  logic              flag_wd_i,
  input  logic              mlen_we_i,
  input  logic [CNT_W-1:0]  mlen_wd_i,
  output logic [CNT_W-1:0]  cap_o,
  output logic              flag_o,
  output logic [MLEN_W-1:0] mlen_o
);
  logic [CNT_W-1:0]  cap_q;
  logic              flag_q, flag_d;
  logic [MLEN_W-1:0] mlen_q;

  always_comb begin
    flag_d = flag_q;
    if (flag_we_i && !flag_wd_i) flag_d = 1'b0;
    if (accept_i)                flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cap_q <= '0;
    else if (accept_i) cap_q <= cnt_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mlen_q <= '0;
    else if (mlen_we_i) mlen_q <= mlen_wd_i[MLEN_W-1:0];
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign mlen_o = mlen_q;
endmodule

// File: rtl/icm_capture_mask.sv
module icm_capture_mask
  import icm_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int MW = MLEN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_val,
  input  logic          cnt_tick,
  input  logic          cap_in,
  input  logic          edge_sel,
  input  logic          mask_en,
  input  logic          mlen_we,
  input  logic [CW-1:0] mlen_wd,
  output logic [CW-1:0] mlen_rd,
  input  logic          flag_we,
  input  logic          flag_wd,
  output logic [CW-1:0] cap_value,
  output logic          cap_flag
);
  localparam int PAD_W = CW - MW - 1;

  logic          edge_pulse;
  logic          win_active;
  logic          accept;
  logic          arm;
  logic [MW-1:0] mlen;
  logic [CW-1:0] span;

  icm_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (cap_in),
    .sel_i   (edge_sel_e'(edge_sel)),
    .pulse_o (edge_pulse)
  );

  assign accept = edge_pulse & ~win_active;
  assign arm    = mask_en & (mlen != '0);
  assign span   = {{PAD_W{1'b0}}, mlen, 1'b0};

  icm_mask_win #(.CNT_W(CW)) u_win (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept),
    .arm_i      (arm),
    .base_i     (cnt_val),
    .span_i     (span),
    .cnt_val_i  (cnt_val),
    .cnt_tick_i (cnt_tick),
    .active_o   (win_active)
  );

  icm_cap_regs #(.CNT_W(CW), .MLEN_W(MW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .cnt_val_i (cnt_val),
    .flag_we_i (flag_we),
    .flag_wd_i (flag_wd),
    .mlen_we_i (mlen_we),
    .mlen_wd_i (mlen_wd),
    .cap_o     (cap_value),
    .flag_o    (cap_flag),
    .mlen_o    (mlen)
  );

  assign mlen_rd = {{(CW-MW){1'b0}}, mlen};
endmodule

// File: rtl/icm_capture_mask_chk.sv
module icm_capture_mask_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt_val,
  input logic          cnt_tick,
  input logic          mask_en,
  input logic          mlen_we,
  input logic [CW-1:0] mlen_wd,
  input logic [CW-1:0] mlen_rd,
  input logic [CW-1:0] cap_value,
  input logic          cap_flag,
  input logic          accept,
  input logic          win_active
);
  // R2
  mlen_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mlen_we |=> (mlen_rd == {8'h00, $past(mlen_wd[7:0])}));

  // R3
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cap_value == $past(cnt_val)));

  // R4
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_active |=> $stable(cap_value));

  // R6
  no_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (!mask_en || mlen_rd == '0)) |=> !win_active);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cap_flag);

  // R9
  tickless_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_active && !cnt_tick) |=> win_active);
endmodule

bind icm_capture_mask icm_capture_mask_chk #(.CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_val    (cnt_val),
  .cnt_tick   (cnt_tick),
  .mask_en    (mask_en),
  .mlen_we    (mlen_we),
  .mlen_wd    (mlen_wd),
  .mlen_rd    (mlen_rd),
  .cap_value  (cap_value),
  .cap_flag   (cap_flag),
  .accept     (accept),
  .win_active (win_active)
);

// File: tb/icm_capture_mask_tb.sv
`timescale 1ns/1ps
module icm_capture_mask_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cnt_val;
  logic        cnt_tick;
  logic        cap_in;
  logic        edge_sel;
  logic        mask_en;
  logic        mlen_we;
  logic [15:0] mlen_wd;
  logic [15:0] mlen_rd;
  logic        flag_we;
  logic        flag_wd;
  logic [15:0] cap_value;
  logic        cap_flag;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  icm_capture_mask u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
    .cap_in(cap_in), .edge_sel(edge_sel), .mask_en(mask_en),
    .mlen_we(mlen_we), .mlen_wd(mlen_wd), .mlen_rd(mlen_rd),
    .flag_we(flag_we), .flag_wd(flag_wd),
    .cap_value(cap_value), .cap_flag(cap_flag)
  );

  // {cnt, tick, cin, exp_cap, exp_flag}; blanking length 3, window 6 counts
  localparam logic [34:0] VEC [14] = '{
    {16'd100, 1'b1, 1'b1, 16'd100, 1'b1},  // R3 accepted, end 106
    {16'd101, 1'b1, 1'b0, 16'd100, 1'b1},
    {16'd102, 1'b1, 1'b1, 16'd100, 1'b1},  // R4 masked
    {16'd103, 1'b1, 1'b0, 16'd100, 1'b1},
    {16'd104, 1'b1, 1'b1, 16'd100, 1'b1},  // R4 masked
    {16'd105, 1'b1, 1'b0, 16'd100, 1'b1},
    {16'd106, 1'b1, 1'b1, 16'd100, 1'b1},  // R5 closing cycle masked
    {16'd107, 1'b1, 1'b0, 16'd100, 1'b1},
    {16'd108, 1'b1, 1'b1, 16'd108, 1'b1},  // R5 accepted after close, end 114
    {16'd109, 1'b1, 1'b0, 16'd108, 1'b1},
    {16'd114, 1'b0, 1'b0, 16'd108, 1'b1},  // R9 no tick, stays open
    {16'd114, 1'b1, 1'b1, 16'd108, 1'b1},  // R9/R5 closes now, edge masked
    {16'd115, 1'b1, 1'b0, 16'd108, 1'b1},
    {16'd116, 1'b1, 1'b1, 16'd116, 1'b1}   // R5 accepted
  };

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [15:0] c, input logic t, input logic ci);
    cnt_val  = c;
    cnt_tick = t;
    cap_in   = ci;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_mlen(input logic [15:0] d);
    mlen_we = 1'b1;
    mlen_wd = d;
    @(posedge clk);
    @(negedge clk);
    mlen_we = 1'b0;
  endtask

  task automatic write_flag(input logic d);
    flag_we = 1'b1;
    flag_wd = d;
    @(posedge clk);
    @(negedge clk);
    flag_we = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cnt_val = '0; cnt_tick = 1'b1; cap_in = 1'b0;
    edge_sel = 1'b0; mask_en = 1'b0; mlen_we = 1'b0; mlen_wd = '0;
    flag_we = 1'b0; flag_wd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check16("R1 cap_value", cap_value, 16'h0000);
    check1 ("R1 cap_flag", cap_flag, 1'b0);
    check16("R1 mlen_rd", mlen_rd, 16'h0000);

    write_mlen(16'h0003);
    mask_en = 1'b1;
    for (int i = 0; i < 14; i++) begin
      step(VEC[i][34:19], VEC[i][18], VEC[i][17]);
      check16($sformatf("R4/R5 table cap step %0d", i), cap_value, VEC[i][16:1]);
      check1 ($sformatf("R8 table flag step %0d", i), cap_flag, VEC[i][0]);
    end
    step(16'd122, 1'b1, 1'b0);  // close window

    // R2 upper byte ignored
    write_mlen(16'hABCD);
    check16("R2 upper byte", mlen_rd, 16'h00CD);
    write_mlen(16'h0000);
    check16("R2 zero", mlen_rd, 16'h0000);

    // R6 length zero with blanking on
    step(16'd301, 1'b1, 1'b1);
    step(16'd302, 1'b1, 1'b0);
    step(16'd303, 1'b1, 1'b1);
    check16("R6 zero length", cap_value, 16'd303);

    // R6 blanking off with nonzero length
    mask_en = 1'b0;
    write_mlen(16'h0005);
    step(16'd310, 1'b1, 1'b0);
    step(16'd311, 1'b1, 1'b1);
    step(16'd312, 1'b1, 1'b0);
    step(16'd313, 1'b1, 1'b1);
    check16("R6 disabled", cap_value, 16'd313);

    // R7 end point latched at capture
    mask_en = 1'b1;
    write_mlen(16'h0002);
    step(16'd400, 1'b1, 1'b0);
    step(16'd401, 1'b1, 1'b1);  // end 405
    write_mlen(16'd50);
    step(16'd404, 1'b1, 1'b0);
    step(16'd405, 1'b1, 1'b0);  // closes
    step(16'd406, 1'b1, 1'b1);
    check16("R7 latched end", cap_value, 16'd406);
    step(16'd506, 1'b1, 1'b0);  // close window of length 50

    // R5 wrap past 16'hFFFF
    write_mlen(16'h0080);
    step(16'hFFF0, 1'b1, 1'b1);  // end 16'h00F0
    step(16'h0010, 1'b1, 1'b0);
    step(16'h0011, 1'b1, 1'b1);
    check16("R5 wrap masked", cap_value, 16'hFFF0);
    step(16'h00EF, 1'b1, 1'b0);
    step(16'h00F0, 1'b1, 1'b1);
    check16("R5 wrap close masked", cap_value, 16'hFFF0);
    step(16'h00F1, 1'b1, 1'b0);
    step(16'h00F2, 1'b1, 1'b1);
    check16("R5 wrap accepted", cap_value, 16'h00F2);
    step(16'h01F2, 1'b1, 1'b0);  // close

    // R8 flag behaviour
    write_mlen(16'h0000);
    write_flag(1'b1);
    check1("R8 write one keeps", cap_flag, 1'b1);
    write_flag(1'b0);
    check1("R8 write zero clears", cap_flag, 1'b0);
    flag_we = 1'b1; flag_wd = 1'b0;
    step(16'h0300, 1'b1, 1'b1);
    flag_we = 1'b0;
    check1("R8 set beats clear", cap_flag, 1'b1);
    check16("R3 capture with clear", cap_value, 16'h0300);

    // R3 falling edge select
    edge_sel = 1'b1;
    step(16'h0320, 1'b1, 1'b0);
    check16("R3 falling captures", cap_value, 16'h0320);
    step(16'h0321, 1'b1, 1'b1);
    check16("R3 rising ignored", cap_value, 16'h0320);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule